// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a host on a simple request/acknowledge bus and an external asynchronous static RAM of 512K bytes. A host raises a request together with a direction, a 19-bit address and, for stores, a data byte. The controller converts it into chip-select, write-enable and output-enable strobe sequences and a tri-state data bus, split into separate out, in and enable signals. It answers with a single-cycle acknowledge. For loads, the acknowledge comes with the captured byte.

Every analog interval of the memory is entered in nanoseconds and turned into a whole number of clock cycles, rounding up, for a given clock period. The strobe widths, the read access window, the bus turnaround and the recovery wait are all fixed this way when the block is elaborated.

A retention input puts the memory into a deselected low-power state. Leaving that state costs one read cycle time of recovery before the next access.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and after it, mem_cs_no, mem_we_no and mem_oe_no are 1 and mem_dq_oe_o and ack_o are 0. ready_o is 1 once reset is released.
- R2: A load holds mem_cs_no=0, mem_oe_no=0 and mem_we_no=1 with the host address on mem_addr_o for RD cycles. RD is the larger of the access-time and read-cycle counts. The byte on mem_dq_i at the last of those cycles appears on rdata_o together with ack_o in the next cycle.
- R3: A store keeps mem_cs_no=0 and mem_we_no=0 overlapped for exactly WP cycles. WP is the largest of the write-pulse, select-to-end, address-to-end and data-setup counts, and of the write-cycle count minus one. During the overlap mem_oe_no=1 and mem_dq_oe_o=1, and mem_dq_o carries the host byte.
- R4: A store ends in one cycle in which only the terminating strobe has risen, with the data still driven. Parameter WR_END_CS=1 makes chip select the terminating strobe. WR_END_CS=0 makes write enable the terminating strobe.
- R5: mem_dq_oe_o is never 1 while mem_cs_no=0 and mem_oe_no=0. It rises no earlier than TURN clock edges after the edge that ended a load. TURN is the larger of the output-disable and deselect float counts.
- R6: ready_o is 0 from the edge that accepts a request until the access is finished. A request is accepted only on an edge where ready_o is 1.
- R7: ack_o is a single-cycle pulse per access. From an idle start, it arrives RD+1 rising edges after the request is raised for a load, and WP+1 rising edges after for a store.
- R8: While retain_i is 1 in the idle state, ready_o is 0, mem_cs_no=1, mem_oe_no=1 and mem_dq_oe_o=0. Requests raised during this time are not accepted.
- R9: After retain_i falls, ready_o becomes 1 only after REC+1 rising edges. REC is the read-cycle count.
- R10: Each count equals ceil(ns*1000/CLK_PERIOD_PS), and at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request, held until ack_o |
| wr_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 19 | Host byte address |
| wdata_i | input | 8 | Store data |
| retain_i | input | 1 | Enter low-power retention while idle |
| ready_o | output | 1 | Controller can take a request this cycle |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured load data |
| mem_addr_o | output | 19 | Memory address |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven towards memory |
| mem_dq_i | input | 8 | Data returned from memory |
| mem_dq_oe_o | output | 1 | Enable for the data driver |

## Verification
The assertions assume three things about the host: it keeps req_i, wr_i, addr_i and wdata_i steady from raising a request until it sees ack_o, it never changes them mid-access, and it uses retain_i only as a level. The bench drives all host inputs at falling edges. It drops the request in the same falling-edge slot in which it observes the acknowledge, and it clears req_i before it releases retain_i, so the recovery count starts from a quiet host. The memory model returns wrong data until the access window has elapsed. A model write happens only during a real select/write overlap, so early capture and misplaced strobes show up as wrong bytes.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_ACK,
    ST_WR_WAIT,
    ST_WR_PULSE,
    ST_WR_END,
    ST_RETAIN,
    ST_RECOVER
  } sram_st_e;

  // ceil(ns / period), never below one cycle
  function automatic int ns_to_cyc(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          drv_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= dq_i;
  end

  assign dq_o    = wdata_i;
  assign dq_oe_o = drv_i;

  // R3
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_i && $past(drv_i)) |-> $stable(wdata_i));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 19,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_RC_NS       = 15,
  parameter int T_ACC_NS      = 15,
  parameter int T_OE_ACC_NS   = 6,
  parameter int T_WC_NS       = 15,
  parameter int T_WP_NS       = 8,
  parameter int T_CW_NS       = 12,
  parameter int T_AW_NS       = 8,
  parameter int T_DS_NS       = 7,
  parameter int T_OHZ_NS      = 5,
  parameter int T_CHZ_NS      = 6,
  parameter bit WR_END_CS     = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          retain_i,
  output logic          ready_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe_o
);

  localparam int P        = CLK_PERIOD_PS;
  localparam int RD_CYC   = imax(imax(ns_to_cyc(T_ACC_NS, P), ns_to_cyc(T_OE_ACC_NS, P)),
                                 ns_to_cyc(T_RC_NS, P));
  localparam int WP_CYC   = imax(imax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_CW_NS, P)),
                                 imax(imax(ns_to_cyc(T_AW_NS, P), ns_to_cyc(T_DS_NS, P)),
                                      ns_to_cyc(T_WC_NS, P) - 1));
  localparam int TURN_CYC = imax(ns_to_cyc(T_OHZ_NS, P), ns_to_cyc(T_CHZ_NS, P));
  localparam int REC_CYC  = ns_to_cyc(T_RC_NS, P);
  localparam int MAX_CYC  = imax(RD_CYC, imax(WP_CYC, REC_CYC));
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam int TTW      = $clog2(TURN_CYC + 1);

  sram_st_e       state_q, state_d;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           accept;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic           turn_load, turn_zero;
  logic           cap, drv;
  logic           end_cs_n, end_we_n;

  // strobe levels in the closing cycle of a store
  generate
    if (WR_END_CS) begin : g_end_cs
      assign end_cs_n = 1'b1;
      assign end_we_n = 1'b0;
    end else begin : g_end_we
      assign end_cs_n = 1'b0;
      assign end_we_n = 1'b1;
    end
  endgenerate

  assign ready_o = (state_q == ST_IDLE) && !retain_i;
  assign accept  = ready_o && req_i;
  assign ack_o   = (state_q == ST_RD_ACK) || (state_q == ST_WR_END);

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    turn_load = 1'b0;
    cap       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (retain_i) begin
          state_d = ST_RETAIN;
        end else if (req_i) begin
          if (!wr_i) begin
            state_d  = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = TW'(RD_CYC - 1);
          end else if (turn_zero) begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = TW'(WP_CYC - 1);
          end else begin
            state_d  = ST_WR_WAIT;
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          cap       = 1'b1;
          turn_load = 1'b1;
          state_d   = ST_RD_ACK;
        end
      end
      ST_RD_ACK: state_d = ST_IDLE;
      ST_WR_WAIT: begin
        if (turn_zero) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = TW'(WP_CYC - 1);
        end
      end
      ST_WR_PULSE: if (tmr_zero) state_d = ST_WR_END;
      ST_WR_END:   state_d = ST_IDLE;
      ST_RETAIN: begin
        if (!retain_i) begin
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = TW'(REC_CYC - 1);
        end
      end
      ST_RECOVER: if (tmr_zero) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  always_comb begin
    mem_cs_no = 1'b1;
    mem_we_no = 1'b1;
    mem_oe_no = 1'b1;
    drv       = 1'b0;
    case (state_q)
      ST_RD: begin
        mem_cs_no = 1'b0;
        mem_oe_no = 1'b0;
      end
      ST_WR_PULSE: begin
        mem_cs_no = 1'b0;
        mem_we_no = 1'b0;
        drv       = 1'b1;
      end
      ST_WR_END: begin
        mem_cs_no = end_cs_n;
        mem_we_no = end_we_n;
        drv       = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_addr_o = addr_q;

  sram_cycle_timer #(.W(TW)) u_acc_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sram_cycle_timer #(.W(TTW)) u_turn_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (turn_load),
    .val_i  (TTW'(TURN_CYC - 1)),
    .zero_o (turn_zero)
  );

  sram_dq_path #(.DW(DW)) u_dq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .drv_i   (drv),
    .wdata_i (wdata_q),
    .dq_i    (mem_dq_i),
    .rdata_o (rdata_o),
    .dq_o    (mem_dq_o),
    .dq_oe_o (mem_dq_oe_o)
  );

  // checker-side run counters
  logic          ovl;
  logic [TW:0]   ovl_cnt;
  logic [TW-1:0] rec_cnt;
  assign ovl = !mem_cs_no && !mem_we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovl_cnt <= '0;
      rec_cnt <= '0;
    end else begin
      ovl_cnt <= ovl ? ovl_cnt + 1'b1 : '0;
      rec_cnt <= (state_q == ST_RECOVER) ? rec_cnt + 1'b1 : '0;
    end
  end

  // R3
  write_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl |-> (mem_oe_no && mem_dq_oe_o));
  // R3
  wp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovl) |-> (int'(ovl_cnt) == WP_CYC));
  // R4
  wr_end_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovl) |-> (mem_cs_no == WR_END_CS) && (mem_we_no == !WR_END_CS) && mem_dq_oe_o);
  // R5
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_cs_no || mem_oe_no));
  // R5
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> turn_zero);
  // R6
  ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ready_o);
  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R8
  retain_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RETAIN) |-> (mem_cs_no && mem_oe_no && !mem_dq_oe_o && !ready_o));
  // R9
  recover_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER && state_d == ST_IDLE) |-> (int'(rec_cnt) == REC_CYC - 1));

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  localparam int P      = 5000;
  localparam bit END_CS = 1'b1;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP   = mx(cyc(15), cyc(6));
  localparam int WP_EXP   = mx(mx(cyc(8), cyc(12)), mx(mx(cyc(8), cyc(7)), cyc(15) - 1));
  localparam int TURN_EXP = mx(cyc(5), cyc(6));
  localparam int REC_EXP  = cyc(15);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr, retain;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic        ready, ack;
  logic [7:0]  rdata;
  logic [18:0] m_addr;
  logic        cs_n, we_n, oe_n;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'h00;
  logic        dq_oe;

  always #2.5 clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_PS(P), .WR_END_CS(END_CS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .retain_i(retain), .ready_o(ready), .ack_o(ack),
    .rdata_o(rdata), .mem_addr_o(m_addr), .mem_cs_no(cs_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  int checks = 0;
  int errs   = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5C;
  endfunction

  // memory model: valid data only once the access window has elapsed
  logic [7:0] mem_model [logic [18:0]];
  logic [7:0] shadow    [logic [18:0]];
  int acc = 0;

  always @(posedge clk) acc <= (cs_n || oe_n) ? 0 : acc + 1;

  always @(negedge clk) begin
    logic [7:0] rv;
    if (!cs_n && !we_n) mem_model[m_addr] = dq_o;
    rv = mem_model.exists(m_addr) ? mem_model[m_addr] : pat(m_addr);
    dq_i <= (!cs_n && !oe_n && we_n && acc >= RD_EXP - 1) ? rv : ~rv;
  end

  // pin monitor
  logic [7:0] cur_wdata = 8'h00;
  bit prev_ovl = 1'b0, prev_oe = 1'b0;
  int ovl_run = 0, rel = 100;

  always @(negedge clk) begin
    bit ovl;
    if (rst_n) begin
      ovl = !cs_n && !we_n;
      if (!cs_n && !oe_n) rel = 0; else rel++;
      if (ovl) begin
        chk(oe_n == 1'b1, "R3 oe high in write", int'(oe_n), 1);
        chk(dq_oe == 1'b1, "R3 driver on in write", int'(dq_oe), 1);
        chk(dq_o == cur_wdata, "R3 write data", int'(dq_o), int'(cur_wdata));
        ovl_run++;
      end else if (prev_ovl) begin
        chk(ovl_run == WP_EXP, "R3 overlap length", ovl_run, WP_EXP);
        chk(cs_n == END_CS && we_n == !END_CS, "R4 end strobe",
            int'({cs_n, we_n}), int'({END_CS, !END_CS}));
        chk(dq_oe && dq_o == cur_wdata, "R4 data hold", int'(dq_o), int'(cur_wdata));
        ovl_run = 0;
      end
      if (dq_oe && !prev_oe) chk(rel >= TURN_EXP + 1, "R5 turnaround", rel, TURN_EXP + 1);
      if (dq_oe) chk(cs_n || oe_n, "R5 contention", int'({cs_n, oe_n}), 3);
      prev_ovl = ovl;
      prev_oe  = dq_oe;
    end
  end

  // starts and ends at a falling edge
  task automatic op(input bit w, input logic [18:0] a, input logic [7:0] d);
    int n;
    bit rdy;
    logic [7:0] e;
    rdy = ready;
    req = 1'b1; wr = w; addr = a; wdata = d; cur_wdata = d;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) chk(!ready, "R6 busy", int'(ready), 0);
      if (ack || n >= 64) break;
    end
    req = 1'b0;
    chk(ack, "R7 ack seen", int'(ack), 1);
    if (rdy) begin
      if (w) chk(n == WP_EXP + 1, "R7 R10 store latency", n, WP_EXP + 1);
      else   chk(n == RD_EXP + 1, "R7 R10 load latency", n, RD_EXP + 1);
    end
    if (w) shadow[a] = d;
    else begin
      e = shadow.exists(a) ? shadow[a] : pat(a);
      chk(rdata == e, "R2 load data", int'(rdata), int'(e));
    end
    @(negedge clk);
    chk(!ack, "R7 single pulse", int'(ack), 0);
  endtask

  function automatic logic [18:0] sweep_addr(input int i);
    if (i == 0)  return 19'h0;
    if (i == 20) return '1;
    return 19'(1) << (i - 1);
  endfunction

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; retain = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n && we_n && oe_n, "R1 strobes in reset", int'({cs_n, we_n, oe_n}), 7);
    chk(!dq_oe && !ack, "R1 driver/ack in reset", int'({dq_oe, ack}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R1 ready after reset", int'(ready), 1);
    chk(cs_n && we_n && oe_n && !dq_oe, "R1 idle strobes", int'({cs_n, we_n, oe_n, dq_oe}), 14);

    for (int i = 0; i < 21; i++) op(1'b0, sweep_addr(i), 8'h00);
    for (int i = 0; i < 21; i++) op(1'b1, sweep_addr(i), 8'(i * 37 + 11));
    for (int i = 0; i < 21; i++) op(1'b0, sweep_addr(i), 8'h00);
    for (int v = 0; v < 16; v++) begin
      op(1'b1, 19'h2A5A0 ^ 19'(v * 4369), 8'(v * 17) ^ 8'h3C);
      op(1'b0, 19'h2A5A0 ^ 19'(v * 4369), 8'h00);
    end

    // R8: retention ignores a pending request
    retain = 1'b1; req = 1'b1; wr = 1'b0; addr = 19'h00123;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!ready && !ack, "R8 held off", int'({ready, ack}), 0);
      chk(cs_n && oe_n && !dq_oe, "R8 deselected", int'({cs_n, oe_n, dq_oe}), 6);
    end
    req = 1'b0;
    @(negedge clk);
    retain = 1'b0;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ready || n >= 40) break;
    end
    // R9
    chk(n == REC_EXP + 1, "R9 recovery length", n, REC_EXP + 1);
    op(1'b0, sweep_addr(5), 8'h00);
    op(1'b0, 19'h00123, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule